// File: doc/BRIEF.md
# Gear-Down Command Bus Sampler

This block sits on the receiving side of a DDR4-style command bus. It captures the address, command and control pins and passes each accepted command on. After reset it samples on every rising clock edge (1N). When a mode-register-set command writes a 1 into bit 3 of mode register 3, the block arms itself for gear-down operation. It then waits for a sync pulse on chip select and locks its sampling phase to the edge where that pulse appeared. From then on, only every second rising edge is a sampling edge (2N), with the clock frequency unchanged. A later mode-register-set that writes a 0 into that bit returns the block to 1N.

Accepted commands appear one cycle after their sampling edge, as a registered copy of the pins with a one-cycle `cmd_valid` strobe. The command bus cannot be stalled, so the output stream has no back-pressure. The consumer must take every strobe in the cycle it appears, and the fields are only meaningful while `cmd_valid` is high. `mode_status` shows the current gear mode.

Top module: `gds_sampler`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) leaves `mode_status` at 0 (normal 1N) and `cmd_valid` low from the next cycle on.
- R2: In normal mode, every rising edge with `cs_n` low produces `cmd_valid` high in the following cycle. The cmd_* fields equal the pin values on that edge, and back-to-back commands are all forwarded.
- R3: An edge with `cs_n` high (deselect) is never forwarded, in any mode, whatever the other pins carry.
- R4: A mode-register-set command is `cs_n`=0, `act_n`=1, `ras_n`=0, `cas_n`=0, `we_n`=0. The register number is {`bg[0]`,`ba[1:0]`}. In normal mode, such a command to register 3 with `addr[3]`=1 is forwarded and moves `mode_status` to 1 (armed) after that edge. Any other register, or `addr[3]`=0, leaves the mode unchanged.
- R5: While armed, no command is forwarded.
- R6: While armed, a sync pulse is an edge T with `cs_n` low where the edges T-1 and T+1 both have `cs_n` high. T-1 must come after the arming edge. `mode_status` becomes 2 (locked) after edge T+1.
- R7: While armed, a `cs_n` low period of two or more edges is not a sync pulse, and the block stays armed.
- R8: In locked mode, the sampling edges are T+2, T+4, T+6 and so on, counted from the sync edge T, whether T falls on an even or an odd clock count.
- R9: In locked mode, edges between sampling edges are ignored, including mode-register-set commands. Nothing is forwarded and the mode is unchanged.
- R10: In locked mode, a mode-register-set to register 3 with `addr[3]`=0 on a sampling edge is forwarded and returns `mode_status` to 0, and the very next edge is sampled. With `addr[3]`=1 the block stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge used |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank address |
| addr | input | 18 | Address bus |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_cs_n | output | 1 | Captured chip select |
| cmd_act_n | output | 1 | Captured activate strobe |
| cmd_ras_n | output | 1 | Captured row strobe |
| cmd_cas_n | output | 1 | Captured column strobe |
| cmd_we_n | output | 1 | Captured write enable |
| cmd_bg | output | 2 | Captured bank group |
| cmd_ba | output | 2 | Captured bank address |
| cmd_addr | output | 18 | Captured address |
| mode_status | output | 2 | 0 normal 1N, 1 armed, 2 locked 2N |

## Verification
In 1N mode the capture is driven with back-to-back commands and with deselects that carry active-looking strobes. This separates a correct chip-select gate from one keyed on the other pins. Mode-register writes go to a wrong register, carry the wrong bit value, and land on off-phase edges, which shows that arming and exit depend on both the decode and the sampling phase. Sync is tried with a multi-edge low period, and with single-edge pulses on both even and odd clock counts, so that a phase fixed to reset is told apart from one locked to the pulse. In locked mode, commands driven on every edge and commands driven only off-phase show that exactly the alternate edges are taken.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [1:0] {
    GM_NORMAL = 2'd0,
    GM_ARMED  = 2'd1,
    GM_LOCKED = 2'd2
  } gear_mode_e;

  // Active-low strobe pattern that marks a mode-register write
  function automatic logic is_mode_write(input logic cs_n, input logic act_n,
                                         input logic ras_n, input logic cas_n,
                                         input logic we_n);
    return !cs_n && act_n && !ras_n && !cas_n && !we_n;
  endfunction

endpackage

// File: rtl/gds_cmd_decode.sv
module gds_cmd_decode
  import gds_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 18,
  parameter int GD_MR  = 3,
  parameter int GD_BIT = 3
) (
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              bg_lsb,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_cmd,
  output logic              gd_set,
  output logic              gd_clr
);
  localparam int SEL_W = BA_W + 1;
  localparam logic [SEL_W-1:0] MR_ID = SEL_W'(GD_MR);

  logic [SEL_W-1:0] mr_sel;
  logic             hit_mr;

  always_comb begin
    mr_sel = {bg_lsb, ba};
    is_cmd = !cs_n;
    hit_mr = is_mode_write(cs_n, act_n, ras_n, cas_n, we_n) && (mr_sel == MR_ID);
    gd_set = hit_mr && addr[GD_BIT];
    gd_clr = hit_mr && !addr[GD_BIT];
  end

endmodule

// File: rtl/gds_sync_detect.sv
module gds_sync_detect #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic cs_n,
  output logic sync_hit
);
  localparam int AGE_W = $clog2(SETTLE + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(SETTLE);

  logic [AGE_W-1:0] age;
  logic [1:0]       cs_hist;

  // cs_hist[0] is the previous edge, cs_hist[1] the one before
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_hist <= 2'b11;
      age     <= '0;
    end else begin
      cs_hist <= {cs_hist[0], cs_n};
      if (!armed)
        age <= '0;
      else if (age != AGE_TOP)
        age <= age + 1'b1;
    end
  end

  // Pulse edge and the edge before it must both lie inside the armed window
  always_comb begin
    sync_hit = armed && (age == AGE_TOP) && cs_n && !cs_hist[0] && cs_hist[1];
  end

endmodule

// File: rtl/gds_gear_fsm.sv
module gds_gear_fsm
  import gds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       gd_set,
  input  logic       gd_clr,
  input  logic       sync_hit,
  output gear_mode_e mode,
  output logic       sample_slot
);
  logic on_phase;

  always_comb begin
    unique case (mode)
      GM_NORMAL: sample_slot = 1'b1;
      GM_LOCKED: sample_slot = on_phase;
      default:   sample_slot = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= GM_NORMAL;
      on_phase <= 1'b0;
    end else begin
      unique case (mode)
        GM_NORMAL: begin
          on_phase <= 1'b0;
          if (gd_set) mode <= GM_ARMED;
        end
        GM_ARMED: begin
          if (sync_hit) begin
            mode     <= GM_LOCKED;
            on_phase <= 1'b1;
          end
        end
        GM_LOCKED: begin
          on_phase <= !on_phase;
          if (on_phase && gd_clr) mode <= GM_NORMAL;
        end
        default: mode <= GM_NORMAL;
      endcase
    end
  end

endmodule

// File: rtl/gds_cmd_capture.sv
module gds_cmd_capture #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '1;
    end else begin
      valid <= take;
      if (take) dout <= din;
    end
  end

endmodule

// File: rtl/gds_sampler.sv
module gds_sampler
  import gds_pkg::*;
#(
  parameter int BG_W   = 2,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 18,
  parameter int GD_MR  = 3,
  parameter int GD_BIT = 3,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              cmd_cs_n,
  output logic              cmd_act_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BG_W-1:0]   cmd_bg,
  output logic [BA_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        mode_status
);
  localparam int CTL_W = 5;
  localparam int W     = CTL_W + BG_W + BA_W + ADDR_W;

  logic       is_cmd, gd_set, gd_clr, sync_hit, sample_slot;
  gear_mode_e mode;
  logic [W-1:0] pins, held;

  gds_cmd_decode #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .GD_MR(GD_MR), .GD_BIT(GD_BIT)
  ) u_dec (
    .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bg_lsb(bg[0]), .ba(ba), .addr(addr),
    .is_cmd(is_cmd), .gd_set(gd_set), .gd_clr(gd_clr)
  );

  gds_sync_detect #(.SETTLE(SETTLE)) u_sync (
    .clk(clk), .rst(rst), .armed(mode == GM_ARMED), .cs_n(cs_n),
    .sync_hit(sync_hit)
  );

  gds_gear_fsm u_fsm (
    .clk(clk), .rst(rst), .gd_set(gd_set), .gd_clr(gd_clr),
    .sync_hit(sync_hit), .mode(mode), .sample_slot(sample_slot)
  );

  assign pins = {cs_n, act_n, ras_n, cas_n, we_n, bg, ba, addr};

  gds_cmd_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .take(sample_slot && is_cmd), .din(pins),
    .valid(cmd_valid), .dout(held)
  );

  assign {cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n,
          cmd_bg, cmd_ba, cmd_addr} = held;
  assign mode_status = mode;

endmodule

// File: rtl/gds_sampler_chk.sv
module gds_sampler_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 18,
  parameter int GD_MR  = 3,
  parameter int GD_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              act_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              bg_lsb,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              cmd_valid,
  input logic              cmd_cs_n,
  input logic [1:0]        mode_status
);
  localparam int SEL_W = BA_W + 1;
  localparam logic [SEL_W-1:0] MR_ID = SEL_W'(GD_MR);

  logic mr_write;
  assign mr_write = !cs_n && act_n && !ras_n && !cas_n && !we_n && ({bg_lsb, ba} == MR_ID);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (mode_status == 2'd0 && !cmd_valid)); // R1

  AST_VALID_HAS_CS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !cmd_cs_n); // R3

  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd1 && $past(mode_status) == 2'd0) |-> $past(mr_write && addr[GD_BIT])); // R4

  AST_SILENT_ARMED: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_status) == 2'd1) |-> !cmd_valid); // R5

  AST_LOCK_FROM_ARMED: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd2 && $past(mode_status) != 2'd2) |-> $past(mode_status) == 2'd1); // R6

  AST_NO_ADJACENT_2N: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd2 && $past(mode_status) == 2'd2 && $past(cmd_valid)) |-> !cmd_valid); // R9

  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 2'd0 && $past(mode_status) == 2'd2) |-> $past(mr_write && !addr[GD_BIT])); // R10

endmodule

bind gds_sampler gds_sampler_chk #(
  .BA_W(BA_W), .ADDR_W(ADDR_W), .GD_MR(GD_MR), .GD_BIT(GD_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .bg_lsb(bg[0]), .ba(ba), .addr(addr),
  .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n), .mode_status(mode_status)
);

// File: tb/gds_sampler_tb.sv
`timescale 1ns/1ps
module gds_sampler_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bg = '0, ba = '0;
  logic [17:0] addr = '0;
  logic cmd_valid, cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0] cmd_bg, cmd_ba, mode_status;
  logic [17:0] cmd_addr;

  always #2.5 clk = ~clk;

  gds_sampler u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bg(bg), .ba(ba), .addr(addr),
    .cmd_valid(cmd_valid), .cmd_cs_n(cmd_cs_n), .cmd_act_n(cmd_act_n),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_bg(cmd_bg), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .mode_status(mode_status)
  );

  int checks = 0, errors = 0, cyc_n = 0;
  bit done = 1'b0;

  // Behavioural reference: gear mode, phase, chip-select history, armed age
  int m_mode = 0;
  bit m_ph = 0;
  bit h1 = 1, h2 = 1;
  int m_age = 0;
  bit e_valid = 0;
  logic [26:0] e_f = '1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit a, input bit r, input bit ca,
                     input bit w, input logic [1:0] g, input logic [1:0] b,
                     input logic [17:0] ad, input string tag);
    bit slot, mrs, mr3;
    cs_n = c; act_n = a; ras_n = r; cas_n = ca; we_n = w;
    bg = g; ba = b; addr = ad;
    slot = (m_mode == 0) || (m_mode == 2 && m_ph);
    mrs  = !c && a && !r && !ca && !w;
    mr3  = mrs && ({g[0], b} == 3'd3);
    e_valid = slot && !c;
    if (e_valid) e_f = {c, a, r, ca, w, g, b, ad};
    if (m_mode == 0) begin
      if (mr3 && ad[3]) begin m_mode = 1; m_age = 0; end
    end else if (m_mode == 1) begin
      if (m_age >= 2 && c && !h1 && h2) begin m_mode = 2; m_ph = 1; end
      else if (m_age < 2) m_age++;
    end else begin
      if (m_ph && mr3 && !ad[3]) m_mode = 0;
      m_ph = !m_ph;
    end
    h2 = h1; h1 = c;
    @(posedge clk);
    cyc_n++;
    @(negedge clk);
    check(mode_status == m_mode[1:0], tag, "mode_status", 32'(mode_status), 32'(m_mode));
    check(cmd_valid == e_valid, tag, "cmd_valid", 32'(cmd_valid), 32'(e_valid));
    if (e_valid)
      check({cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_bg, cmd_ba, cmd_addr} == e_f,
            tag, "fields",
            32'({cmd_cs_n, cmd_act_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_bg, cmd_ba, cmd_addr}),
            32'(e_f));
  endtask

  task automatic idle(input string tag);
    cyc(1, 1, 1, 1, 1, 2'd0, 2'd0, 18'h0, tag);
  endtask

  task automatic rd(input logic [17:0] ad, input string tag);
    cyc(0, 1, 1, 0, 1, ad[1:0], ad[3:2], ad, tag);
  endtask

  task automatic mrs(input int mr, input bit b3, input string tag);
    cyc(0, 1, 0, 0, 0, {1'b0, 1'(mr >> 2)}, 2'(mr), 18'h00a00 | (18'(b3) << 3), tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    cs_n = 1; act_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    repeat (3) @(posedge clk);
    m_mode = 0; m_ph = 0; h1 = 1; h2 = 1; m_age = 0; e_valid = 0;
    @(negedge clk);
    check(mode_status == 2'd0, tag, "reset mode", 32'(mode_status), 0);
    check(cmd_valid == 1'b0, tag, "reset valid", 32'(cmd_valid), 0);
    rst = 1'b0;
  endtask

  // Single-edge chip-select pulse on a chosen clock-count parity
  task automatic sync_on(input int parity, input string tag);
    while ((cyc_n % 2) != parity) idle(tag);
    rd(18'h1, tag);
    idle(tag);
    check(mode_status == 2'd2, tag, "locked after pulse", 32'(mode_status), 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset("R1");

    // 1N capture
    rd(18'h00123, "R2");
    rd(18'h3abcd, "R2");
    cyc(0, 0, 1, 1, 1, 2'd2, 2'd1, 18'h15a5a, "R2");
    idle("R3");
    cyc(1, 0, 0, 0, 0, 2'd3, 2'd3, 18'h3ffff, "R3");
    rd(18'h2468a, "R2");

    // Mode decode: wrong register, wrong bit, then arm
    mrs(2, 1, "R4");
    mrs(3, 0, "R4");
    mrs(7, 1, "R4");
    mrs(3, 1, "R4");
    check(mode_status == 2'd1, "R4", "armed", 32'(mode_status), 1);

    // Long low periods are not a sync pulse, nothing forwarded
    rd(18'h111, "R7");
    rd(18'h222, "R7");
    idle("R5");
    rd(18'h333, "R7");
    rd(18'h334, "R7");
    rd(18'h335, "R7");
    idle("R7");
    check(mode_status == 2'd1, "R7", "still armed", 32'(mode_status), 1);
    idle("R5");

    // Lock on even parity, commands on every edge
    sync_on(0, "R6");
    for (int i = 0; i < 8; i++) rd(18'(16'h1000 + i), "R8");

    // Off-phase only traffic
    if (m_ph) idle("R9");
    for (int i = 0; i < 4; i++) begin
      rd(18'(16'h2000 + i), "R9");
      idle("R9");
    end
    mrs(3, 0, "R9");
    check(mode_status == 2'd2, "R9", "off-phase exit ignored", 32'(mode_status), 2);
    mrs(3, 1, "R10");
    check(mode_status == 2'd2, "R10", "set keeps lock", 32'(mode_status), 2);
    idle("R10");
    mrs(3, 0, "R10");
    check(mode_status == 2'd0, "R10", "exit to 1N", 32'(mode_status), 0);
    rd(18'h0beef, "R10");
    check(cmd_valid == 1'b1, "R10", "first 1N edge", 32'(cmd_valid), 1);

    // Rearm and lock on odd parity
    mrs(3, 1, "R4");
    idle("R6");
    idle("R6");
    sync_on(1, "R6");
    for (int i = 0; i < 8; i++) rd(18'(16'h3000 + i), "R8");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 2'd1, 2'd2, 18'(i), "R3");

    // Reset from locked and from armed
    do_reset("R1");
    rd(18'h4444, "R2");
    mrs(3, 1, "R4");
    idle("R5");
    do_reset("R1");
    rd(18'h5555, "R2");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule